// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block collects one cache line from a downstream memory port on behalf of a cache controller that has missed. The requester names the line address and the index of the word it actually needs. The memory side then returns the line one word per beat, starting with that needed word and wrapping around the line. The buffer hands the first word straight to the requester on a one-cycle early-data output, so the pipeline can continue while the other beats are still arriving.

Each beat carries an error flag. An error on the first (critical) beat is reported to the requester as an abort alongside the early data. An error on any beat blocks the cache RAM update, so a partly bad line never reaches the cache. When all beats have arrived cleanly, the block writes the whole line, together with its address, to the cache RAM in a single cycle. Only one fill is in flight at any time. A new request is taken only while the buffer is idle.

Top module: `line_fill_buffer`

## Requirements
- R1: After reset `busy`, `earlyValid` and `cacheWrEn` are all low.
- R2: A fill request is accepted only while `busy` is low, and `busy` rises in the cycle after acceptance. A request made while `busy` is high is ignored: it changes neither the line address written nor the fill in progress.
- R3: Beats arrive in wrapping order. Beat k (k = 0..LINE_WORDS-1) is stored in word slot (critIdx + k) mod LINE_WORDS. Slot i appears on `cacheWrLine[i*WORD_W +: WORD_W]`.
- R4: `earlyValid` is high for exactly one cycle, in the cycle after the first beat of a fill is taken. `earlyData` then carries that beat's data. Early data never coincides with a cache write.
- R5: `earlyAbort`, qualified by `earlyValid`, is 1 exactly when the first (critical) beat had its error flag set. Errors on later beats never raise it.
- R6: When all beats arrive without error, `cacheWrEn` pulses for one cycle, in the cycle after the last beat. During that pulse `cacheWrAddr` equals the accepted line address.
- R7: If any beat of a fill has its error flag set, `cacheWrEn` stays low for that fill.
- R8: `busy` falls one cycle after the cache write pulse. For an errored fill, `busy` falls in the cycle after the last beat is taken.
- R9: Beats presented while the buffer is idle are ignored and produce no early data and no cache write. Idle cycles between beats of a fill are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fillReq | input | 1 | Fill request strobe |
| fillLineAddr | input | ADDR_W | Line address of the request |
| fillCritIdx | input | $clog2(LINE_WORDS) | Index of the critical word within the line |
| busy | output | 1 | A fill is in progress |
| beatValid | input | 1 | A beat is present on the memory side |
| beatData | input | WORD_W | Beat data word |
| beatErr | input | 1 | Error response for this beat |
| earlyValid | output | 1 | Critical word available (one-cycle pulse) |
| earlyData | output | WORD_W | Critical word |
| earlyAbort | output | 1 | Critical beat was in error |
| cacheWrEn | output | 1 | Single-cycle cache line write |
| cacheWrAddr | output | ADDR_W | Line address for the write |
| cacheWrLine | output | LINE_WORDS*WORD_W | Full line, slot i at bits i*WORD_W upward |

## Verification
The assertions assume that the memory side sends beats only for a fill that has been accepted, and exactly LINE_WORDS of them per fill. They also assume LINE_WORDS is a power of two, so that the wrap works. Stray beats in idle time are the one exception, and the block must ignore them. The bench driver starts a fill only after it sees `busy` low, and it always sends a full set of beats. It varies the critical index, the error positions and the gaps between beats. Deliberate stray beats and overlapping requests are injected only at points where the design must discard them.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } lfbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch address and critical index
    logic store;    // store current beat into the next wrapped slot
    logic first;    // current beat is the critical one
  } lfbStrobes_t;
endpackage

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
  import lfb_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  localparam int IDX_W = $clog2(LINE_WORDS)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fillReq,
  input  logic        beatValid,
  input  logic        beatErr,
  output lfbStrobes_t strobes,
  output logic        busy,
  output logic        cacheWrEn
);
  lfbState_t state, stateNext;
  logic [IDX_W-1:0] beatCnt;
  logic errSeen;
  logic lastBeat;

  always_comb begin
    strobes.capture = (state == ST_IDLE) && fillReq;
    strobes.store   = (state == ST_FILL) && beatValid;
    strobes.first   = strobes.store && (beatCnt == '0);
  end

  assign lastBeat  = strobes.store && (beatCnt == IDX_W'(LINE_WORDS - 1));
  assign busy      = (state != ST_IDLE);
  assign cacheWrEn = (state == ST_WRITE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobes.capture) stateNext = ST_FILL;
      ST_FILL:  if (lastBeat) stateNext = (errSeen || beatErr) ? ST_IDLE : ST_WRITE;
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      errSeen <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobes.capture) begin
        beatCnt <= '0;
        errSeen <= 1'b0;
      end else if (strobes.store) begin
        beatCnt <= beatCnt + 1'b1;
        errSeen <= errSeen || beatErr;
      end
    end
  end

  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cacheWrEn |=> !cacheWrEn) else $error("write pulse longer than one cycle"); // R6
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    cacheWrEn |=> !busy) else $error("busy held after write"); // R8
  AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    cacheWrEn |-> !errSeen) else $error("write after errored beat"); // R7
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && fillReq) |=> busy) else $error("idle request not taken"); // R2
endmodule

// File: rtl/lfb_datapath.sv
module lfb_datapath
  import lfb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int IDX_W  = $clog2(LINE_WORDS),
  localparam int LINE_W = LINE_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lfbStrobes_t       strobes,
  input  logic [ADDR_W-1:0] fillLineAddr,
  input  logic [IDX_W-1:0]  fillCritIdx,
  input  logic [WORD_W-1:0] beatData,
  input  logic              beatErr,
  output logic              earlyValid,
  output logic [WORD_W-1:0] earlyData,
  output logic              earlyAbort,
  output logic [ADDR_W-1:0] cacheWrAddr,
  output logic [LINE_W-1:0] cacheWrLine
);
  logic [ADDR_W-1:0] lineAddrQ;
  logic [IDX_W-1:0]  slotPtr;
  logic [WORD_W-1:0] words [LINE_WORDS];

  // Slot pointer wraps naturally because LINE_WORDS is a power of two
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAddrQ <= '0;
      slotPtr   <= '0;
    end else if (strobes.capture) begin
      lineAddrQ <= fillLineAddr;
      slotPtr   <= fillCritIdx;
    end else if (strobes.store) begin
      slotPtr <= slotPtr + 1'b1;
    end
  end

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) words[i] <= '0;
      else if (strobes.store && (slotPtr == IDX_W'(i))) words[i] <= beatData;
    end
    assign cacheWrLine[i*WORD_W +: WORD_W] = words[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      earlyValid <= 1'b0;
      earlyData  <= '0;
      earlyAbort <= 1'b0;
    end else begin
      earlyValid <= strobes.first;
      if (strobes.first) begin
        earlyData  <= beatData;
        earlyAbort <= beatErr;
      end
    end
  end

  assign cacheWrAddr = lineAddrQ;

  AST_EARLY_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    earlyValid |=> !earlyValid) else $error("early data held"); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capture && !$isunknown(lineAddrQ)) |=> $stable(cacheWrAddr)) else $error("address moved"); // R2
endmodule

// File: rtl/line_fill_buffer.sv
module line_fill_buffer
  import lfb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int IDX_W  = $clog2(LINE_WORDS),
  localparam int LINE_W = LINE_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fillReq,
  input  logic [ADDR_W-1:0] fillLineAddr,
  input  logic [IDX_W-1:0]  fillCritIdx,
  output logic              busy,
  input  logic              beatValid,
  input  logic [WORD_W-1:0] beatData,
  input  logic              beatErr,
  output logic              earlyValid,
  output logic [WORD_W-1:0] earlyData,
  output logic              earlyAbort,
  output logic              cacheWrEn,
  output logic [ADDR_W-1:0] cacheWrAddr,
  output logic [LINE_W-1:0] cacheWrLine
);
  lfbStrobes_t strobes;

  lfb_ctrl #(.LINE_WORDS(LINE_WORDS)) i_ctrl (
    .clk(clk), .rstN(rstN), .fillReq(fillReq), .beatValid(beatValid),
    .beatErr(beatErr), .strobes(strobes), .busy(busy), .cacheWrEn(cacheWrEn)
  );

  lfb_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fillLineAddr(fillLineAddr),
    .fillCritIdx(fillCritIdx), .beatData(beatData), .beatErr(beatErr),
    .earlyValid(earlyValid), .earlyData(earlyData), .earlyAbort(earlyAbort),
    .cacheWrAddr(cacheWrAddr), .cacheWrLine(cacheWrLine)
  );

  AST_EARLY_NOT_WITH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cacheWrEn |-> !earlyValid) else $error("early data during write"); // R4
endmodule

// File: tb/test_line_fill_buffer.sv
`timescale 1ns/1ps
module test_line_fill_buffer;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int LW     = 8;
  localparam int IDX_W  = 3;
  localparam int LINE_W = LW * WORD_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fillReq = 1'b0;
  logic [ADDR_W-1:0] fillLineAddr = '0;
  logic [IDX_W-1:0] fillCritIdx = '0;
  logic busy;
  logic beatValid = 1'b0;
  logic [WORD_W-1:0] beatData = '0;
  logic beatErr = 1'b0;
  logic earlyValid;
  logic [WORD_W-1:0] earlyData;
  logic earlyAbort;
  logic cacheWrEn;
  logic [ADDR_W-1:0] cacheWrAddr;
  logic [LINE_W-1:0] cacheWrLine;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [WORD_W:0] earlyQ [$];
  logic [ADDR_W+LINE_W-1:0] writeQ [$];

  always #2.5 clk = ~clk;

  line_fill_buffer i_line_fill_buffer (
    .clk(clk), .rstN(rstN), .fillReq(fillReq), .fillLineAddr(fillLineAddr),
    .fillCritIdx(fillCritIdx), .busy(busy), .beatValid(beatValid),
    .beatData(beatData), .beatErr(beatErr), .earlyValid(earlyValid),
    .earlyData(earlyData), .earlyAbort(earlyAbort), .cacheWrEn(cacheWrEn),
    .cacheWrAddr(cacheWrAddr), .cacheWrLine(cacheWrLine)
  );

  task automatic check(input bit ok, input string req, input logic [LINE_W+ADDR_W-1:0] act,
                       input logic [LINE_W+ADDR_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear (R4 R5 R3 R6 R7 R9)
  always @(negedge clk) begin
    if (rstN && earlyValid) begin
      if (earlyQ.size() == 0) check(1'b0, "R9 unexpected early", {earlyAbort, earlyData}, 0);
      else begin
        logic [WORD_W:0] e;
        e = earlyQ.pop_front();
        check({earlyAbort, earlyData} == e, "R4/R5 early data", {earlyAbort, earlyData}, e);
      end
    end
    if (rstN && cacheWrEn) begin
      if (writeQ.size() == 0) check(1'b0, "R7 unexpected write", {cacheWrAddr, cacheWrLine}, 0);
      else begin
        logic [ADDR_W+LINE_W-1:0] w;
        w = writeQ.pop_front();
        check({cacheWrAddr, cacheWrLine} == w, "R3/R6 line write", {cacheWrAddr, cacheWrLine}, w);
      end
    end
  end

  // Driver: one full fill; errMask bit k flags beat k; gap inserts idle cycles between beats
  task automatic doFill(input logic [ADDR_W-1:0] addr, input int crit, input logic [LW-1:0] errMask,
                        input logic [WORD_W-1:0] seed, input int gap, input bit overlapReq);
    logic [LINE_W-1:0] line;
    line = '0;
    while (busy) @(negedge clk);
    fillReq = 1'b1;
    fillLineAddr = addr;
    fillCritIdx = IDX_W'(crit);
    @(negedge clk);
    fillReq = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    earlyQ.push_back({errMask[0], seed});
    for (int k = 0; k < LW; k++) begin
      logic [WORD_W-1:0] d;
      d = seed + WORD_W'(k) * 32'h0101_0101;
      line[((crit + k) % LW) * WORD_W +: WORD_W] = d;
      beatValid = 1'b1;
      beatData = d;
      beatErr = errMask[k];
      if (overlapReq && k == 3) begin
        fillReq = 1'b1;                 // R2: must be ignored while busy
        fillLineAddr = ~addr;
        fillCritIdx = IDX_W'(crit + 5);
      end
      @(negedge clk);
      fillReq = 1'b0;
      beatValid = 1'b0;
      beatErr = 1'b0;
      if (k != LW - 1) repeat (gap) @(negedge clk);
    end
    if (errMask == '0) begin
      writeQ.push_back({addr, line});
      check(cacheWrEn == 1'b1 && busy == 1'b1, "R6 write one cycle after last beat", {cacheWrEn, busy}, 2'b11);
      @(negedge clk);
      check(busy == 1'b0, "R8 busy low after write", busy, 0);
    end else begin
      check(busy == 1'b0 && cacheWrEn == 1'b0, "R8/R7 errored fill ends", {cacheWrEn, busy}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && earlyValid == 0 && cacheWrEn == 0, "R1 reset state", {busy, earlyValid, cacheWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R9: stray beats while idle
    for (int s = 0; s < 3; s++) begin
      beatValid = 1'b1; beatData = 32'hDEAD_0000 + s; beatErr = 1'b0;
      @(negedge clk);
    end
    beatValid = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R9 idle beats ignored", busy, 0);
    doFill(32'h0000_1000, 0, 8'h00, 32'h1111_0000, 0, 1'b0);   // R3 crit 0
    doFill(32'h0000_2040, 5, 8'h00, 32'h2222_0000, 0, 1'b0);   // R3 wrap
    doFill(32'h0000_3080, 7, 8'h00, 32'h3333_0000, 2, 1'b0);   // R9 gaps
    doFill(32'h0000_40C0, 2, 8'h01, 32'h4444_0000, 0, 1'b0);   // R5 critical error
    doFill(32'h0000_5100, 3, 8'h40, 32'h5555_0000, 1, 1'b0);   // R7 late error, no abort
    doFill(32'h0000_6140, 6, 8'h80, 32'h6666_0000, 0, 1'b0);   // R7 error on last beat
    doFill(32'h0000_7180, 1, 8'h00, 32'h7777_0000, 0, 1'b1);   // R2 overlapping request
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2 ignored request left no fill", busy, 0);
    check(earlyQ.size() == 0 && writeQ.size() == 0, "R6 all expected results seen",
          earlyQ.size() + writeQ.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule